// File: doc/BRIEF.md
# Configurable I/O Pad Cell

This block connects one external pad to the internal fabric. A short serial configuration chain sets its behaviour: whether the pad drives or only listens, whether the outbound and inbound data each pass straight through or through a register, and whether each direction flips polarity. The pad is modelled with three separate wires: a data value to drive, an output enable, and the value seen on the pad.

Configuration shifts in one bit per clock while the load strobe is high. For the whole load window the pad driver stays off, so a partly loaded word never puts a value onto the pad. The inbound path watches the pad in every direction setting, so the fabric can read back a value it is driving. A synchronous reset clears the two path registers and leaves the loaded configuration as it was.

Top module: `iocell_pad`

## Requirements
- R1: The configuration word is 5 bits and loads LSB first, one bit per rising edge while `cfg_load` is high. After five such edges, bit 0 is the first bit shifted in and bit 4 is the last. Bit 0 = drive enable (1 = output), bit 1 = outbound registered, bit 2 = outbound inverted, bit 3 = inbound registered, bit 4 = inbound inverted. While `cfg_load` is low the word does not change.
- R2: With drive enable at 1 and `cfg_load` low, `pad_oe` is 1.
- R3: With drive enable at 0, `pad_oe` is 0.
- R4: While `cfg_load` is high, `pad_oe` is 0, whatever the configuration holds.
- R5: With outbound registered at 0, `pad_out` equals `core_out` XOR outbound-inverted in the same cycle.
- R6: With outbound registered at 1, `pad_out` equals the value of `core_out` XOR outbound-inverted taken at the previous rising edge, which is one cycle later than in R5.
- R7: With inbound registered at 0, `core_in` equals `pad_in` XOR inbound-inverted in the same cycle.
- R8: With inbound registered at 1, `core_in` equals the value of `pad_in` XOR inbound-inverted taken at the previous rising edge.
- R9: The inbound path follows `pad_in` in both direction settings, including while the pad drives.
- R10: A rising edge with `rst` high clears both path registers to 0. Registered outputs then read 0 and the configuration word is kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; registered paths and the configuration chain use its rising edge |
| rst | input | 1 | Synchronous active-high reset of the path registers |
| cfg_load | input | 1 | Shift enable for the configuration chain; keeps the driver off |
| cfg_din | input | 1 | Serial configuration bit |
| core_out | input | 1 | Fabric data headed for the pad |
| core_in | output | 1 | Pad data delivered to the fabric |
| pad_out | output | 1 | Value presented to the pad driver |
| pad_oe | output | 1 | Pad driver enable; 0 means high impedance |
| pad_in | input | 1 | Value sensed on the pad |

## Verification
A wrong configuration bit shows at the ports in the first cycle after the load. A bad drive bit flips `pad_oe`. A bad invert bit flips data in that direction. A bad register bit moves data by one cycle, so the output matches the previous cycle's input instead of the current one. A stale or uncleared path register shows on the registered output in the first cycle after reset or after the data changes. The bench compares every output in every cycle, so each such fault shows within one clock of its cause.

// File: rtl/iocell_pkg.sv
package iocell_pkg;

    localparam int CFG_W  = 5;
    localparam int DATA_W = 1;

    // Field order sets the serial position: the last member is bit 0.
    typedef struct packed {
        logic in_flip;
        logic in_hold;
        logic out_flip;
        logic out_hold;
        logic drive;
    } iocell_cfg_t;

    function automatic logic [DATA_W-1:0] polarity(input logic [DATA_W-1:0] d,
                                                   input logic flip);
        return d ^ {DATA_W{flip}};
    endfunction

endpackage

// File: rtl/iocell_cfg_chain.sv
module iocell_cfg_chain
    import iocell_pkg::*;
#(
    parameter int LEN = CFG_W
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        shift_en,
    input  logic        shift_bit,
    output iocell_cfg_t cfg
);

    logic [LEN-1:0] chain_q;

    // Not cleared by rst: the loaded word must survive a path reset.
    always_ff @(posedge clk) begin
        if (shift_en) begin
            chain_q <= {shift_bit, chain_q[LEN-1:1]};
        end
    end

    assign cfg = iocell_cfg_t'(chain_q[CFG_W-1:0]);

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
        !$past(shift_en) |-> $stable(cfg)); // R1

endmodule

// File: rtl/iocell_path.sv
module iocell_path
    import iocell_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         hold,
    input  logic         flip,
    input  logic [W-1:0] d,
    output logic [W-1:0] y
);

    logic [W-1:0] d_pol;
    logic [W-1:0] q;

    assign d_pol = d ^ {W{flip}};

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= d_pol;
        end
    end

    assign y = hold ? q : d_pol;

    AST_PATH_CLEAR: assert property (@(posedge clk)
        ($past(rst) && hold) |-> (y == '0)); // R10

endmodule

// File: rtl/iocell_pad.sv
module iocell_pad
    import iocell_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cfg_load,
    input  logic cfg_din,
    input  logic core_out,
    output logic core_in,
    output logic pad_out,
    output logic pad_oe,
    input  logic pad_in
);

    iocell_cfg_t cfg;

    iocell_cfg_chain #(.LEN(CFG_W)) chain_i (
        .clk       (clk),
        .rst       (rst),
        .shift_en  (cfg_load),
        .shift_bit (cfg_din),
        .cfg       (cfg)
    );

    iocell_path #(.W(DATA_W)) out_path_i (
        .clk  (clk),
        .rst  (rst),
        .hold (cfg.out_hold),
        .flip (cfg.out_flip),
        .d    (core_out),
        .y    (pad_out)
    );

    // The inbound path samples the pad whatever the direction.
    iocell_path #(.W(DATA_W)) in_path_i (
        .clk  (clk),
        .rst  (rst),
        .hold (cfg.in_hold),
        .flip (cfg.in_flip),
        .d    (pad_in),
        .y    (core_in)
    );

    assign pad_oe = cfg.drive & ~cfg_load;

    AST_OE_ON: assert property (@(posedge clk) disable iff (rst)
        (cfg.drive && !cfg_load) |-> pad_oe); // R2
    AST_OE_OFF_DIR: assert property (@(posedge clk) disable iff (rst)
        !cfg.drive |-> !pad_oe); // R3
    AST_OE_OFF_LOAD: assert property (@(posedge clk) disable iff (rst)
        cfg_load |-> !pad_oe); // R4
    AST_OUT_DIRECT: assert property (@(posedge clk) disable iff (rst)
        !cfg.out_hold |-> (pad_out == polarity(core_out, cfg.out_flip))); // R5
    AST_OUT_REG: assert property (@(posedge clk) disable iff (rst)
        (cfg.out_hold && !$past(cfg_load) && !$past(rst))
        |-> (pad_out == $past(polarity(core_out, cfg.out_flip)))); // R6
    AST_IN_DIRECT: assert property (@(posedge clk) disable iff (rst)
        !cfg.in_hold |-> (core_in == polarity(pad_in, cfg.in_flip))); // R7 R9
    AST_IN_REG: assert property (@(posedge clk) disable iff (rst)
        (cfg.in_hold && !$past(cfg_load) && !$past(rst))
        |-> (core_in == $past(polarity(pad_in, cfg.in_flip)))); // R8 R9

endmodule

// File: tb/iocell_pad_tb.sv
module iocell_pad_tb_top;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_load = 1'b0;
    logic cfg_din = 1'b0;
    logic core_out = 1'b0;
    logic pad_in = 1'b0;
    logic core_in, pad_out, pad_oe;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    // Bench's view of the loaded word (bit0 drive .. bit4 inbound invert)
    logic m_drive = 1'b0, m_oreg = 1'b0, m_oinv = 1'b0, m_ireg = 1'b0, m_iinv = 1'b0;
    logic m_qo = 1'b0, m_qi = 1'b0;

    always #4 clk = ~clk;

    iocell_pad dut_i (
        .clk      (clk),
        .rst      (rst),
        .cfg_load (cfg_load),
        .cfg_din  (cfg_din),
        .core_out (core_out),
        .core_in  (core_in),
        .pad_out  (pad_out),
        .pad_oe   (pad_oe),
        .pad_in   (pad_in)
    );

    // Expected register contents from R6, R8, R10
    always @(posedge clk) begin
        if (rst) begin
            m_qo <= 1'b0;
            m_qi <= 1'b0;
        end else begin
            m_qo <= core_out ^ m_oinv;
            m_qi <= pad_in ^ m_iinv;
        end
    end

    function automatic logic exp_pad_out();
        return m_oreg ? m_qo : (core_out ^ m_oinv);
    endfunction

    function automatic logic exp_core_in();
        return m_ireg ? m_qi : (pad_in ^ m_iinv);
    endfunction

    task automatic chk(input string tag, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    // R1: shift five bits LSB first; R4 checked on every load cycle
    task automatic load_word(input logic [4:0] w);
        @(negedge clk);
        cfg_load = 1'b1;
        for (int i = 0; i < 5; i++) begin
            cfg_din = w[i];
            #1 chk("R4 oe during load", pad_oe, 1'b0);
            @(negedge clk);
        end
        cfg_load = 1'b0;
        {m_iinv, m_ireg, m_oinv, m_oreg, m_drive} = w;
        @(negedge clk);
        #1 chk(m_drive ? "R1 R2 oe after load" : "R1 R3 oe after load", pad_oe, m_drive);
    endtask

    task automatic run_cycles(input int n);
        logic prev_rst = 1'b0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            prev_rst = rst;
            core_out = 1'($urandom);
            pad_in   = 1'($urandom);
            rst      = ($urandom % 12) == 0;
            #1;
            chk(m_drive ? "R2 oe" : "R3 oe", pad_oe, m_drive);
            if (prev_rst && m_oreg)
                chk("R10 outbound reg cleared", pad_out, 1'b0);
            else
                chk(m_oreg ? "R6 outbound reg" : "R5 outbound direct", pad_out, exp_pad_out());
            if (prev_rst && m_ireg)
                chk("R10 inbound reg cleared", core_in, 1'b0);
            else if (m_drive)
                chk(m_ireg ? "R8 R9 readback reg" : "R7 R9 readback direct", core_in, exp_core_in());
            else
                chk(m_ireg ? "R8 inbound reg" : "R7 inbound direct", core_in, exp_core_in());
        end
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // Directed: fill both registers with 1, then reset; config must survive
        load_word(5'b11111);
        core_out = 1'b0;
        pad_in = 1'b0;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R10 reset state pad_out", pad_out, 1'b0);
        chk("R10 reset state core_in", core_in, 1'b0);
        chk("R10 config kept", pad_oe, 1'b1);
        @(negedge clk);
        #1;
        chk("R6 inverted after reset", pad_out, 1'b1);
        chk("R8 inverted after reset", core_in, 1'b1);

        // Every configuration word, random data and reset pulses
        for (int w = 0; w < 32; w++) begin
            load_word(5'(w));
            run_cycles(40);
        end

        // Random reload order
        for (int j = 0; j < 16; j++) begin
            load_word(5'($urandom));
            run_cycles(25);
        end

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule